// File: doc/BRIEF.md
# Soft Mute Gain Ramp Controller

This block produces the gain coefficient for a sample multiplier in an audio output path. The gain moves smoothly between full scale and zero, one linear step per audio frame, when a mute request is raised or dropped. It also drives an active-low mute-control line for an external analogue mute switch. That line goes low only once the gain has reached zero. It goes high again as soon as the request is withdrawn, before the gain starts to rise. The ramp is counted in frames, and its length scales with the sample-rate speed mode: 1152 frames in single speed, twice that in double speed and four times that in quad speed.

The block keeps a normalized position counter with 4 × 1152 = 4608 units of span. Each frame tick during a ramp moves the position by 4, 2 or 1 units, depending on the speed captured when the ramp began. A constant-divisor mapping turns the position into the 16-bit gain. Five states sequence the operation. S_HOLD covers reset and an invalid clock ratio, with gain at zero. S_RAMP_UP is the rising ramp. S_FULL is full scale. S_RAMP_DN is the falling ramp. S_MUTED is gain at zero while the mute request is active.

The transitions are as follows:
- hold_to_up: S_HOLD→S_RAMP_UP when the ratio is valid and the request is 1.
- hold_to_muted: S_HOLD→S_MUTED when the ratio is valid and the request is 0.
- muted_to_up: S_MUTED→S_RAMP_UP when the request returns to 1.
- up_done: S_RAMP_UP→S_FULL on the tick that reaches the end.
- up_reverse: S_RAMP_UP→S_RAMP_DN when the request goes to 0.
- full_to_dn: S_FULL→S_RAMP_DN when the request goes to 0.
- dn_done: S_RAMP_DN→S_MUTED on the tick that reaches zero.
- dn_reverse: S_RAMP_DN→S_RAMP_UP when the request returns to 1.
- ratio_lost: any state→S_HOLD whenever the ratio flag is 0.

Top module: `soft_mute_ramp`

## Requirements
- R1: While rst_n is 0, gain is 0x0000, ramp_busy is 0 and mute_ctl_n is 0.
- R2: mute_req_n = 0 requests mute and 1 requests normal operation. While muted, frame ticks leave gain at 0x0000 and mute_ctl_n at 0.
- R3: speed_mode encoding: 00 single, 01 double, 10 quad, and 11 is treated as quad. A full ramp in either direction takes exactly 1152, 2304 or 4608 frame ticks respectively.
- R4: After k ticks of a rising ramp of N frames, starting from zero, gain equals floor(k·65535/N). During a falling ramp, it equals floor((N−k)·65535/N) after k ticks. Gain changes only on frame ticks.
- R5: mute_ctl_n stays 1 throughout a falling ramp. It goes to 0 in the same cycle that gain reaches 0x0000 at the end of the ramp.
- R6: One clock after mute_req_n is sampled 1 while muted, mute_ctl_n is 1 and ramp_busy is 1, with gain still 0x0000.
- R7: When ratio_ok is 0, mute_ctl_n is 0 in the same cycle. From the next clock onward, gain is 0x0000 and ramp_busy is 0. When the ratio recovers, the block starts from zero gain. It ramps up if mute_req_n is 1 and otherwise stays muted.
- R8: When the request reverses during a ramp, the ramp changes direction from the current gain without any jump.
- R9: A change of speed_mode during a ramp does not alter that ramp. It applies from the next ramp that starts from rest.
- R10: ramp_busy is 1 exactly while a ramp is in progress. It drops in the cycle that gain reaches its end value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per left/right frame |
| mute_req_n | input | 1 | Mute request, 0 = mute |
| speed_mode | input | 2 | 00 single, 01 double, 10/11 quad |
| ratio_ok | input | 1 | Master-to-frame clock ratio is valid |
| gain | output | 16 | Gain coefficient, 0x0000 to 0xFFFF |
| ramp_busy | output | 1 | A ramp is in progress |
| mute_ctl_n | output | 1 | Active-low external mute control |

## Verification
A request change sampled at a clock edge appears on ramp_busy and mute_ctl_n right after that edge. A frame tick sampled at an edge updates gain right after that edge. A drop of ratio_ok pulls mute_ctl_n low within the same cycle, and gain clears one edge later. The bench drives every input just after a falling edge and samples just after the following falling edge, so each result is checked exactly one edge after its cause. The ratio-loss check on mute_ctl_n is taken in the same half-cycle as the drive. Full rising and falling ramps are swept in every speed code, and the gain is compared against the arithmetic formula on every tick.

// File: rtl/smr_pkg.sv
package smr_pkg;

    typedef enum logic [2:0] {
        S_HOLD    = 3'd0,
        S_RAMP_UP = 3'd1,
        S_FULL    = 3'd2,
        S_RAMP_DN = 3'd3,
        S_MUTED   = 3'd4
    } smr_state_t;

    // Rates below quad share one code each; 2'd3 aliases quad.
    localparam logic [1:0] SPD_SINGLE = 2'd0;
    localparam logic [1:0] SPD_DOUBLE = 2'd1;
    localparam logic [1:0] SPD_QUAD   = 2'd2;

    // Number of speed doublings covered by the position span.
    localparam int SPD_LEVELS = 2;

endpackage

// File: rtl/smr_step_sel.sv
module smr_step_sel
    import smr_pkg::*;
#(
    parameter int POS_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       speed_in,
    output logic [POS_W-1:0] step_o
);

    logic [1:0] spd_q;
    logic [1:0] spd_sat;
    logic [1:0] shamt;

    // Capture the speed only while the sequencer rests.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spd_q <= SPD_SINGLE;
        end else if (load) begin
            spd_q <= speed_in;
        end
    end

    always_comb begin
        spd_sat = (spd_q > SPD_QUAD) ? SPD_QUAD : spd_q;
        shamt   = 2'(SPD_LEVELS) - spd_sat;
        step_o  = POS_W'(1) << shamt;
    end

endmodule

// File: rtl/smr_gain_map.sv
module smr_gain_map #(
    parameter int POS_W    = 13,
    parameter int GAIN_W   = 16,
    parameter int FULL_POS = 4608
) (
    input  logic [POS_W-1:0]  pos_i,
    output logic [GAIN_W-1:0] gain_o
);

    localparam int PW = POS_W + GAIN_W;
    localparam logic [PW-1:0] GMAX_W = PW'((64'd1 << GAIN_W) - 64'd1);
    localparam logic [PW-1:0] FULL_W = PW'(FULL_POS);

    logic [PW-1:0] prod;

    always_comb begin
        prod   = PW'(pos_i) * GMAX_W;
        gain_o = GAIN_W'(prod / FULL_W);
    end

    // R4
    always_comb begin
        if (pos_i == POS_W'(FULL_POS)) begin
            gain_top_chk: assert (gain_o == {GAIN_W{1'b1}});
        end
        if (pos_i == '0) begin
            gain_floor_chk: assert (gain_o == '0);
        end
    end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
    import smr_pkg::*;
#(
    parameter int BASE_LEN = 1152,
    parameter int GAIN_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              mute_req_n,
    input  logic [1:0]        speed_mode,
    input  logic              ratio_ok,
    output logic [GAIN_W-1:0] gain,
    output logic              ramp_busy,
    output logic              mute_ctl_n
);

    localparam int FULL_POS = BASE_LEN << SPD_LEVELS;
    localparam int POS_W    = $clog2(FULL_POS + 1);
    localparam logic [POS_W-1:0] FULL_P = POS_W'(FULL_POS);

    smr_state_t       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [POS_W-1:0] step;
    logic             at_rest;

    assign at_rest = (state_q == S_HOLD) || (state_q == S_FULL) ||
                     (state_q == S_MUTED);

    smr_step_sel #(.POS_W(POS_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (at_rest),
        .speed_in (speed_mode),
        .step_o   (step)
    );

    smr_gain_map #(.POS_W(POS_W), .GAIN_W(GAIN_W), .FULL_POS(FULL_POS)) u_map (
        .pos_i  (pos_q),
        .gain_o (gain)
    );

    // Next-state and position logic
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (!ratio_ok) begin
            state_d = S_HOLD;
            pos_d   = '0;
        end else begin
            unique case (state_q)
                S_HOLD:    state_d = mute_req_n ? S_RAMP_UP : S_MUTED;
                S_MUTED:   if (mute_req_n) state_d = S_RAMP_UP;
                S_FULL:    if (!mute_req_n) state_d = S_RAMP_DN;
                S_RAMP_UP: begin
                    if (frame_tick) pos_d = pos_q + step;
                    if (frame_tick && (pos_q == FULL_P - step)) state_d = S_FULL;
                    else if (!mute_req_n) state_d = S_RAMP_DN;
                end
                S_RAMP_DN: begin
                    if (frame_tick) pos_d = pos_q - step;
                    if (frame_tick && (pos_q == step)) state_d = S_MUTED;
                    else if (mute_req_n) state_d = S_RAMP_UP;
                end
                default:   state_d = S_HOLD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_HOLD;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // Outputs
    always_comb begin
        ramp_busy  = (state_q == S_RAMP_UP) || (state_q == S_RAMP_DN);
        mute_ctl_n = ratio_ok && (ramp_busy || (state_q == S_FULL));
    end

    // R5
    mutec_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mute_ctl_n) && ratio_ok) |-> (gain == '0));

    // R6
    mutec_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_ctl_n) |-> $past(mute_req_n));

    // R4
    pos_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_ok && !frame_tick) |=> $stable(pos_q));

    // R4
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_ok && frame_tick && ramp_busy) |=>
        ((pos_q == $past(pos_q) + $past(step)) ||
         (pos_q == $past(pos_q) - $past(step))));

    // R9
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_busy |=> $stable(step));

    // R7
    ratio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_ok |=> (gain == '0 && !ramp_busy));

endmodule

// File: tb/sim_soft_mute_ramp.sv
module sim_soft_mute_ramp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic        mute_req_n = 1'b0;
    logic [1:0]  speed_mode = 2'd0;
    logic        ratio_ok = 1'b1;
    logic [15:0] gain;
    logic        ramp_busy;
    logic        mute_ctl_n;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    soft_mute_ramp u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .mute_req_n (mute_req_n),
        .speed_mode (speed_mode),
        .ratio_ok   (ratio_ok),
        .gain       (gain),
        .ramp_busy  (ramp_busy),
        .mute_ctl_n (mute_ctl_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint expv);
        n_chk = n_chk + 1;
        if (act != expv) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic longint exp_gain(input longint k, input longint n);
        return (k * 65535) / n;
    endfunction

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        #1;
    endtask

    function automatic int len_of(input logic [1:0] s);
        return (s == 2'd0) ? 1152 : (s == 2'd1) ? 2304 : 4608;
    endfunction

    task automatic ramp_up_from_zero(input int n);
        mute_req_n = 1'b1;
        cyc();
        check("R6 mutec released", mute_ctl_n, 1);
        check("R6 busy at start", ramp_busy, 1);
        check("R6 gain before step", gain, 0);
        for (int k = 1; k <= n; k++) begin
            frame();
            check("R4 rising gain", gain, exp_gain(k, n));
            check("R10 busy rising", ramp_busy, (k != n));
        end
        check("R3 full after N ticks", gain, 65535);
    endtask

    task automatic ramp_down_from_full(input int n);
        mute_req_n = 1'b0;
        cyc();
        check("R10 busy at fall start", ramp_busy, 1);
        check("R5 mutec high at fall start", mute_ctl_n, 1);
        for (int k = 1; k <= n; k++) begin
            frame();
            check("R4 falling gain", gain, exp_gain(n - k, n));
            check("R5 mutec on fall", mute_ctl_n, (k != n));
        end
        check("R3 zero after N ticks", ramp_busy, 0);
    endtask

    initial begin
        // R1 reset state
        repeat (3) cyc();
        check("R1 gain in reset", gain, 0);
        check("R1 busy in reset", ramp_busy, 0);
        check("R1 mutec in reset", mute_ctl_n, 0);
        rst_n = 1'b1;
        cyc();
        cyc();
        // R2 muted: ticks have no effect
        frame();
        frame();
        check("R2 gain while muted", gain, 0);
        check("R2 mutec while muted", mute_ctl_n, 0);
        check("R2 busy while muted", ramp_busy, 0);

        // R3 sweep every speed code
        for (int s = 0; s < 4; s++) begin
            speed_mode = 2'(s);
            cyc();
            ramp_up_from_zero(len_of(2'(s)));
            ramp_down_from_full(len_of(2'(s)));
        end

        // R8 reversal mid-ramp
        speed_mode = 2'd0;
        cyc();
        mute_req_n = 1'b1;
        cyc();
        for (int k = 1; k <= 100; k++) frame();
        check("R8 gain before reversal", gain, exp_gain(100, 1152));
        mute_req_n = 1'b0;
        cyc();
        check("R8 no jump at reversal", gain, exp_gain(100, 1152));
        check("R8 busy after reversal", ramp_busy, 1);
        for (int j = 1; j <= 40; j++) begin
            frame();
            check("R8 falling after reversal", gain, exp_gain(100 - j, 1152));
        end
        mute_req_n = 1'b1;
        cyc();
        check("R8 no jump at second reversal", gain, exp_gain(60, 1152));
        for (int k = 61; k <= 1152; k++) begin
            frame();
            check("R8 rising after reversal", gain, exp_gain(k, 1152));
        end
        check("R10 busy ends at full", ramp_busy, 0);

        // R9 speed change during a falling ramp
        mute_req_n = 1'b0;
        cyc();
        for (int k = 1; k <= 10; k++) frame();
        speed_mode = 2'd2;
        for (int k = 11; k <= 1152; k++) begin
            frame();
            check("R9 old speed kept", gain, exp_gain(1152 - k, 1152));
        end
        check("R9 ramp ended on old length", ramp_busy, 0);
        cyc();
        mute_req_n = 1'b1;
        cyc();
        for (int k = 1; k <= 5; k++) begin
            frame();
            check("R9 new speed on next ramp", gain, exp_gain(k, 4608));
        end

        // R7 ratio loss
        ratio_ok = 1'b0;
        #1;
        check("R7 mutec drops same cycle", mute_ctl_n, 0);
        cyc();
        check("R7 gain cleared", gain, 0);
        check("R7 busy cleared", ramp_busy, 0);
        frame();
        check("R7 tick ignored while invalid", gain, 0);
        ratio_ok = 1'b1;
        cyc();
        check("R7 recovery ramps up", ramp_busy, 1);
        check("R7 recovery mutec", mute_ctl_n, 1);
        check("R7 recovery from zero", gain, 0);
        frame();
        check("R7 first step after recovery", gain, exp_gain(1, 4608));
        ratio_ok = 1'b0;
        mute_req_n = 1'b0;
        cyc();
        ratio_ok = 1'b1;
        cyc();
        cyc();
        frame();
        frame();
        check("R7 recovery muted gain", gain, 0);
        check("R7 recovery muted mutec", mute_ctl_n, 0);
        check("R7 recovery muted busy", ramp_busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule